// File: doc/BRIEF.md
# Two-Level Lookahead Adder/Subtractor

This block adds or subtracts two 16-bit two's-complement operands in a single combinational pass. The operand path uses a control input to pick the operation. With the control high, every bit of the second operand is inverted and the low-order carry is forced to one, so the same adder forms `x - y`. With the control low, the operand passes through unchanged and the low-order carry is zero.

The carry network has two levels. Four 4-bit groups each form per-bit generate (`x & y`) and propagate (`x ^ y`) terms. Each group then computes its internal carries as flat sums of products of those terms and its incoming carry, so no carry waits on the carry below it. Each group also exports a group generate and a group propagate term. A second-level lookahead unit takes the four pairs and the low-order carry, and produces the carries into bits 4, 8, 12 and 16 directly, using the same expansion. The carry out of the top bit comes out unchanged in both modes. The signed overflow flag is the XOR of the carry into the sign bit and the carry out of it.

Top module: `cla_addsub16`

## Requirements
- R1: With `sub_i` = 0, `sum_o` equals `(x_i + y_i) mod 2^16`.
- R2: With `sub_i` = 1, `sum_o` equals `(x_i - y_i) mod 2^16`, formed as `x_i + ~y_i + 1`.
- R3: `carry_o` is bit 16 of `x_i + y_i` in add mode and bit 16 of `x_i + ~y_i + 1` in subtract mode. In subtract mode, 1 means no borrow (`x_i >= y_i` unsigned).
- R4: `ovf_o` is 1 exactly when the true signed result lies outside -32768..32767. This is the same as the carry into bit 15 XOR the carry out of bit 15.
- R5: The carry into each 4-bit group comes from the second-level lookahead unit. It agrees with that group's own carry-out for every input, including all-propagate operands where the low-order carry must reach bit 16.
- R6: Group generate forces the carry out of that group to 1. A group that neither generates nor propagates forces that carry to 0. For the top group, this applies to `carry_o`.
- R7: Corner cases raise overflow: `0x7FFF + 1`, `0x8000 + 0xFFFF`, `0x8000 + 0x8000`, `0x8000 - 1`, `0x7FFF - 0xFFFF` and `0 - 0x8000`.
- R8: All outputs are pure functions of the present inputs. The block holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 16 | First operand, two's complement |
| y_i | input | 16 | Second operand, two's complement |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| sum_o | output | 16 | Result modulo 2^16 |
| carry_o | output | 1 | Carry out of bit 15 (in subtract mode, 1 = no borrow) |
| ovf_o | output | 1 | Signed overflow |

## Verification
The block has no registers, so the sum, carry and overflow are all due in the same cycle their operands are applied. The bench applies each operand set one nanosecond after a rising edge. It samples the three outputs at the following falling edge, when the whole carry network has settled and no new stimulus has yet arrived. The operands, the mode and the expected values change together, so every sample belongs to exactly one stimulus.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned GROUP_W = 4;
  localparam int unsigned N_GRP   = DATA_W / GROUP_W;
endpackage

// File: rtl/cla_lookahead.sv
// Flattened carry lookahead over N generate/propagate pairs.
module cla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] g_i,
  input  logic [N-1:0] p_i,
  input  logic         cin_i,
  output logic [N:0]   c_o,
  output logic         gg_o,
  output logic         gp_o
);
  always_comb begin
    logic term, run;
    c_o[0] = cin_i;
    for (int i = 0; i < N; i++) begin
      // c[i+1] = g[i] | p[i]g[i-1] | ... | p[i..0]cin
      term = g_i[i];
      run  = p_i[i];
      for (int j = i - 1; j >= 0; j--) begin
        term = term | (run & g_i[j]);
        run  = run & p_i[j];
      end
      c_o[i+1] = term | (run & cin_i);
    end
  end

  always_comb begin
    logic term, run;
    term = g_i[N-1];
    run  = p_i[N-1];
    for (int j = N - 2; j >= 0; j--) begin
      term = term | (run & g_i[j]);
      run  = run & p_i[j];
    end
    gg_o = term;
    gp_o = run;
  end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  input  logic          cin_i,
  output logic [GW-1:0] sum_o,
  output logic          gg_o,
  output logic          gp_o,
  output logic          c_msb_o,
  output logic          cout_o
);
  logic [GW-1:0] g, p;
  logic [GW:0]   c;

  assign g = a_i & b_i;
  assign p = a_i ^ b_i;

  cla_lookahead #(.N(GW)) u_la (
    .g_i(g), .p_i(p), .cin_i(cin_i), .c_o(c), .gg_o(gg_o), .gp_o(gp_o)
  );

  assign sum_o   = p ^ c[GW-1:0];
  assign c_msb_o = c[GW-1];
  assign cout_o  = c[GW];

  // R6: group-level terms bound the group's own carry-out
  always_comb begin
    if (gg_o) a_r6_gen_sets_cout: assert (cout_o) else $error("a_r6_gen_sets_cout");
    if (!gg_o && !gp_o) a_r6_kill_clears_cout: assert (!cout_o) else $error("a_r6_kill_clears_cout");
  end
endmodule

// File: rtl/cla_addsub16.sv
module cla_addsub16
  import cla_pkg::*;
(
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o,
  output logic              ovf_o
);
  logic [DATA_W-1:0] y_eff;
  logic [N_GRP-1:0]  grp_g, grp_p, grp_cmsb, grp_cout;
  logic [N_GRP:0]    grp_c;
  logic              top_gg, top_gp;

  assign y_eff = y_i ^ {DATA_W{sub_i}};

  cla_lookahead #(.N(N_GRP)) u_level2 (
    .g_i(grp_g), .p_i(grp_p), .cin_i(sub_i),
    .c_o(grp_c), .gg_o(top_gg), .gp_o(top_gp)
  );

  for (genvar k = 0; k < N_GRP; k++) begin : g_grp
    cla_group #(.GW(GROUP_W)) u_grp (
      .a_i    (x_i[k*GROUP_W +: GROUP_W]),
      .b_i    (y_eff[k*GROUP_W +: GROUP_W]),
      .cin_i  (grp_c[k]),
      .sum_o  (sum_o[k*GROUP_W +: GROUP_W]),
      .gg_o   (grp_g[k]),
      .gp_o   (grp_p[k]),
      .c_msb_o(grp_cmsb[k]),
      .cout_o (grp_cout[k])
    );

    // R5: second-level carry matches the group's own carry-out
    always_comb begin
      a_r5_level2_agrees: assert (grp_c[k+1] == grp_cout[k])
        else $error("a_r5_level2_agrees group %0d", k);
    end
  end

  assign carry_o = grp_c[N_GRP];
  assign ovf_o   = grp_c[N_GRP] ^ grp_cmsb[N_GRP-1];

  always_comb begin
    // R4: overflow only with like-signed operands and a flipped result sign
    if (ovf_o) a_r4_ovf_signs: assert ((x_i[DATA_W-1] == y_eff[DATA_W-1]) &&
                                       (sum_o[DATA_W-1] != x_i[DATA_W-1]))
      else $error("a_r4_ovf_signs");
    // R6: whole-word generate / kill bound the carry out
    if (top_gg) a_r6_top_gen: assert (carry_o) else $error("a_r6_top_gen");
    if (!top_gg && !top_gp) a_r6_top_kill: assert (!carry_o) else $error("a_r6_top_kill");
    // R2: bit 0 sees the mode as its carry-in
    a_r2_lsb: assert (sum_o[0] == (x_i[0] ^ y_i[0])) else $error("a_r2_lsb");
  end
endmodule

// File: tb/cla_addsub16_tb_top.sv
module cla_addsub16_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] x, y, sum;
  logic        sub, cy, ovf;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  cla_addsub16 dut_i (
    .x_i(x), .y_i(y), .sub_i(sub), .sum_o(sum), .carry_o(cy), .ovf_o(ovf)
  );

  // {x, y, sub, sum, carry, ovf}
  localparam int NV = 14;
  localparam logic [50:0] VEC [NV] = '{
    {16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0},
    {16'h7FFF, 16'h0001, 1'b0, 16'h8000, 1'b0, 1'b1},
    {16'h8000, 16'hFFFF, 1'b0, 16'h7FFF, 1'b1, 1'b1},
    {16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1, 1'b0},
    {16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0, 1'b0},
    {16'h0005, 16'h0003, 1'b1, 16'h0002, 1'b1, 1'b0},
    {16'h0003, 16'h0005, 1'b1, 16'hFFFE, 1'b0, 1'b0},
    {16'h8000, 16'h0001, 1'b1, 16'h7FFF, 1'b1, 1'b1},
    {16'h7FFF, 16'hFFFF, 1'b1, 16'h8000, 1'b0, 1'b1},
    {16'h1234, 16'h1234, 1'b1, 16'h0000, 1'b1, 1'b0},
    {16'hAAAA, 16'h5555, 1'b0, 16'hFFFF, 1'b0, 1'b0},
    {16'h0000, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0},
    {16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1, 1'b1},
    {16'h0000, 16'h8000, 1'b1, 16'h8000, 1'b0, 1'b1}
  };

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic s);
    @(posedge clk);
    #1;
    x = a; y = b; sub = s;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] es,
                       input logic ec, input logic ev);
    checks++;
    if (sum !== es || cy !== ec || ovf !== ev) begin
      errors++;
      $display("FAIL %s x=%h y=%h sub=%b: actual sum=%h c=%b v=%b expected sum=%h c=%b v=%b",
               req, x, y, sub, sum, cy, ovf, es, ec, ev);
    end
  endtask

  // behavioural model
  task automatic model_check(input string req);
    logic [15:0] ye;
    logic [16:0] full;
    logic        v;
    ye   = sub ? ~y : y;
    full = {1'b0, x} + {1'b0, ye} + {16'h0, sub};
    v    = (x[15] == ye[15]) && (full[15] != x[15]);
    check(req, full[15:0], full[16], v);
  endtask

  initial begin
    x = '0; y = '0; sub = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R8_idle_zero", 16'h0000, 1'b0, 1'b0);

    // R1 R2 R3 R4 R7 vector table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][50:35], VEC[i][34:19], VEC[i][18]);
      check(VEC[i][18] ? "R2_R3_R4_R7_table" : "R1_R3_R4_R7_table",
            VEC[i][17:2], VEC[i][1], VEC[i][0]);
    end

    // R5: all-propagate chains, carry-in travels across all 16 bits
    for (int i = 0; i < 40; i++) begin
      logic [15:0] r;
      r = 16'($urandom);
      apply(r, ~r, 1'b0);
      check("R5_prop_add", 16'hFFFF, 1'b0, 1'b0);
      apply(r, r, 1'b1);
      check("R5_prop_sub", 16'h0000, 1'b1, 1'b0);
    end
    apply(16'hFFFF, 16'h0000, 1'b1);
    check("R5_R6_sub_zero", 16'hFFFF, 1'b1, 1'b0);

    // R1 R2 R3 R4 random against model
    for (int i = 0; i < 400; i++) begin
      apply(16'($urandom), 16'($urandom), i[0]);
      model_check(sub ? "R2_R3_R4_random" : "R1_R3_R4_random");
    end

    // R8: reapply an earlier stimulus, same result
    apply(16'h1234, 16'h4321, 1'b0);
    check("R8_repeat", 16'h5555, 1'b0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule